// File: doc/BRIEF.md
# Per-Line Table-Driven Transfer Engine

This block moves a few bytes into a set of destination registers during every horizontal blank. Up to eight channels each follow a list in A-side memory. A list entry starts with a line-count byte. In direct mode the data bytes follow that byte in the list. In indirect mode a 16-bit pointer follows it, and that pointer selects the data in a separate bank. At the start of a frame the engine latches an enable mask, clears all per-channel counters, and loads the first entry of every enabled channel.

On each horizontal-blank pulse the engine takes every active channel with a transfer pending, in index order. For each one it sends one group of bytes to B-side addresses `0x2100 + dest + offset`. The group shape comes from the channel's pattern field. The engine then runs a second pass that decrements the line counters. That pass loads the next entry when the low seven bits of a counter reach zero. Bit 7 of the counter selects whether the channel transfers on every line of the run or only on its first line.

A-side reads are issued one at a time, and the data returns on the following cycle. B-side writes carry the byte that was just read. A single-cycle `done_o` marks the end of each frame-start or line pass.

Top module: `hdma_engine`

## Requirements
- R1: A frame-start pulse latches `en_mask_i` as the active mask and clears every line counter and pending flag. It then loads the first entry of each enabled channel, with the pointer starting at that channel's `tbl_addr`. A disabled channel makes no A-side read and no B-side write for the whole frame.
- R2: An entry load reads the count byte at `{tbl_bank, pointer}` into the channel's line counter. Each byte read from the list advances the pointer by one. A-side reads are never issued on two consecutive cycles.
- R3: In indirect mode (control bit 6 set), the count byte is followed by two more list bytes, low byte first and then high byte, which form the indirect address. This applies when the new count is nonzero, or when a higher-numbered channel is still active with a nonzero counter.
- R4: In indirect mode, when neither condition of R3 holds, only one more list byte is read. It becomes the high byte of the indirect address, and the low byte is 0x00.
- R5: A count byte of 0x00 removes the channel from the active mask until the next frame start.
- R6: The pattern field (control bits 2:0) fixes the B-side offsets of one group: 0 gives {0}; 1 gives {0,1}; 2 and 6 give {0,0}; 3 and 7 give {0,0,1,1}; 4 gives {0,1,2,3}; 5 gives {0,1,0,1}. The B-side address is `0x2100 + dest + offset`.
- R7: In direct mode the data bytes are read at `{tbl_bank, pointer}`, and the pointer advances by one per byte sent.
- R8: In indirect mode the data bytes are read at `{ind_bank, indirect address}`, and the indirect address advances by one per byte sent.
- R9: After the transfers of a line, each active channel decrements its counter. Its pending flag then takes bit 7 of the new value. When bits 6:0 of the new value are zero, the next entry is loaded. Every entry load sets the pending flag.
- R10: Both the transfer pass and the counter pass visit the channels in ascending index order.
- R11: `done_o` is high for exactly one cycle at the end of each pass. Frame-start or hblank pulses that arrive while a pass is running are ignored.
- R12: During and after reset there are no A-side reads, no B-side writes and no `done_o` until a pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame-start pulse |
| hblank_i | input | 1 | Horizontal-blank pulse |
| en_mask_i | input | NCH | Channel enable mask, latched at frame start |
| ctrl_i | input | 8*NCH | Per-channel control: bit 7 repeat (unused here), bit 6 indirect, bits 2:0 pattern |
| dest_i | input | 8*NCH | Per-channel B-side register index |
| tbl_addr_i | input | 16*NCH | Per-channel list start address |
| tbl_bank_i | input | 8*NCH | Per-channel list bank |
| ind_bank_i | input | 8*NCH | Per-channel indirect data bank |
| a_rd_o | output | 1 | A-side read strobe |
| a_addr_o | output | 24 | A-side address {bank, address} |
| a_rdata_i | input | 8 | A-side read data, valid the cycle after the strobe |
| b_wr_o | output | 1 | B-side write strobe |
| b_addr_o | output | 16 | B-side address |
| b_wdata_o | output | 8 | B-side write data |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
On every cycle the assertions check a few local properties. A-side reads are paced with one outstanding at a time. Each B-side write follows an A-side read. `done_o` is a single-cycle pulse. Within a transfer pass the channel index never moves backwards. The list-walking rules can only be shown by the bench scenarios, which compare every A-side address and every B-side address and data byte against a behavioural model. Those rules are the truncated versus full indirect pointer fetch, deactivation on a zero count, repeat versus single-shot runs, the eight group shapes, and pulses being ignored while a pass runs.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_XFER, ST_COUNT, ST_RELOAD, ST_DONE
  } hdma_st_e;

  localparam int IND_BIT = 6;
  localparam int REP_BIT = 7;
endpackage

// File: rtl/hdma_pattern.sv
module hdma_pattern (
  input  logic [2:0] mode_i,
  input  logic [1:0] idx_i,
  output logic [1:0] off_o,
  output logic       last_o
);
  always_comb begin
    off_o  = 2'd0;
    last_o = 1'b0;
    unique case (mode_i)
      3'd0: begin off_o = 2'd0;                last_o = (idx_i == 2'd0); end
      3'd1: begin off_o = idx_i;               last_o = (idx_i == 2'd1); end
      3'd2,
      3'd6: begin off_o = 2'd0;                last_o = (idx_i == 2'd1); end
      3'd3,
      3'd7: begin off_o = {1'b0, idx_i[1]};    last_o = (idx_i == 2'd3); end
      3'd4: begin off_o = idx_i;               last_o = (idx_i == 2'd3); end
      default: begin off_o = {1'b0, idx_i[0]}; last_o = (idx_i == 2'd3); end
    endcase
  end
endmodule

// File: rtl/hdma_later.sv
module hdma_later #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] live_i,
  input  logic [CW-1:0]  ch_i,
  output logic           any_o
);
  logic [NCH-1:0] above;
  for (genvar j = 0; j < NCH; j++) begin : g_above
    assign above[j] = live_i[j] && (CW'(j) > ch_i);
  end
  assign any_o = |above;
endmodule

// File: rtl/hdma_engine.sv
module hdma_engine
  import hdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int BKW = 8,
  parameter int DW  = 8,
  parameter int BW  = 16,
  parameter logic [BW-1:0] B_BASE = 16'h2100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               hblank_i,
  input  logic [NCH-1:0]     en_mask_i,
  input  logic [8*NCH-1:0]   ctrl_i,
  input  logic [8*NCH-1:0]   dest_i,
  input  logic [AW*NCH-1:0]  tbl_addr_i,
  input  logic [BKW*NCH-1:0] tbl_bank_i,
  input  logic [BKW*NCH-1:0] ind_bank_i,
  output logic               a_rd_o,
  output logic [BKW+AW-1:0]  a_addr_o,
  input  logic [DW-1:0]      a_rdata_i,
  output logic               b_wr_o,
  output logic [BW-1:0]      b_addr_o,
  output logic [DW-1:0]      b_wdata_o,
  output logic               done_o
);
  localparam int CW = $clog2(NCH);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic [7:0]     ctrl_w  [NCH];
  logic [7:0]     dest_w  [NCH];
  logic [AW-1:0]  tbl_w   [NCH];
  logic [BKW-1:0] tbank_w [NCH];
  logic [BKW-1:0] ibank_w [NCH];
  logic [NCH-1:0] live;

  hdma_st_e       st_q;
  logic [CW-1:0]  ch_q;
  logic [1:0]     step_q, bidx_q;
  logic           rd_wait_q, two_q, ret_cnt_q;
  logic [AW-1:0]  ptr_q [NCH];
  logic [AW-1:0]  iad_q [NCH];
  logic [7:0]     cnt_q [NCH];
  logic [NCH-1:0] act_q, pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign ctrl_w[c]  = ctrl_i[c*8 +: 8];
    assign dest_w[c]  = dest_i[c*8 +: 8];
    assign tbl_w[c]   = tbl_addr_i[c*AW +: AW];
    assign tbank_w[c] = tbl_bank_i[c*BKW +: BKW];
    assign ibank_w[c] = ind_bank_i[c*BKW +: BKW];
    assign live[c]    = act_q[c] && (cnt_q[c] != 8'd0);
  end

  logic       cur_ind, xfer_go, later_live, pat_last, ch_last;
  logic [2:0] cur_mode;
  logic [1:0] pat_off;
  logic [7:0] cnt_dec;

  assign cur_ind  = ctrl_w[ch_q][IND_BIT];
  assign cur_mode = ctrl_w[ch_q][2:0];
  assign xfer_go  = act_q[ch_q] && pend_q[ch_q];
  assign cnt_dec  = cnt_q[ch_q] - 8'd1;
  assign ch_last  = (ch_q == LAST);

  hdma_later #(.NCH(NCH)) u_later (
    .live_i (live),
    .ch_i   (ch_q),
    .any_o  (later_live)
  );

  hdma_pattern u_pat (
    .mode_i (cur_mode),
    .idx_i  (bidx_q),
    .off_o  (pat_off),
    .last_o (pat_last)
  );

  assign a_rd_o    = !rd_wait_q && ((st_q == ST_RELOAD) || (st_q == ST_XFER && xfer_go));
  assign b_wr_o    = rd_wait_q && st_q == ST_XFER && xfer_go;
  assign b_addr_o  = B_BASE + BW'(dest_w[ch_q]) + BW'(pat_off);
  assign b_wdata_o = a_rdata_i;
  assign done_o    = (st_q == ST_DONE);

  always_comb begin
    if (st_q == ST_XFER && cur_ind) a_addr_o = {ibank_w[ch_q], iad_q[ch_q]};
    else                            a_addr_o = {tbank_w[ch_q], ptr_q[ch_q]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ch_q      <= '0;
      step_q    <= '0;
      bidx_q    <= '0;
      rd_wait_q <= 1'b0;
      two_q     <= 1'b0;
      ret_cnt_q <= 1'b0;
      act_q     <= '0;
      pend_q    <= '0;
      for (int c = 0; c < NCH; c++) begin
        ptr_q[c] <= '0;
        iad_q[c] <= '0;
        cnt_q[c] <= '0;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (frame_start_i) begin
            act_q  <= en_mask_i;
            pend_q <= '0;
            for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
            ch_q   <= '0;
            st_q   <= ST_INIT;
          end else if (hblank_i) begin
            ch_q      <= '0;
            bidx_q    <= '0;
            rd_wait_q <= 1'b0;
            st_q      <= ST_XFER;
          end
        end
        ST_INIT: begin
          if (act_q[ch_q]) begin
            ptr_q[ch_q] <= tbl_w[ch_q];
            step_q      <= '0;
            rd_wait_q   <= 1'b0;
            ret_cnt_q   <= 1'b0;
            st_q        <= ST_RELOAD;
          end else if (ch_last) st_q <= ST_DONE;
          else                  ch_q <= ch_q + 1'b1;
        end
        ST_XFER: begin
          if (!xfer_go) begin
            if (ch_last) begin ch_q <= '0; st_q <= ST_COUNT; end
            else ch_q <= ch_q + 1'b1;
          end else if (!rd_wait_q) begin
            rd_wait_q <= 1'b1;
          end else begin
            rd_wait_q <= 1'b0;
            if (cur_ind) iad_q[ch_q] <= iad_q[ch_q] + 1'b1;
            else         ptr_q[ch_q] <= ptr_q[ch_q] + 1'b1;
            if (pat_last) begin
              bidx_q <= '0;
              if (ch_last) begin ch_q <= '0; st_q <= ST_COUNT; end
              else ch_q <= ch_q + 1'b1;
            end else bidx_q <= bidx_q + 1'b1;
          end
        end
        ST_COUNT: begin
          if (act_q[ch_q]) begin
            cnt_q[ch_q]  <= cnt_dec;
            pend_q[ch_q] <= cnt_dec[REP_BIT];
          end
          if (act_q[ch_q] && cnt_dec[6:0] == 7'd0) begin
            step_q    <= '0;
            rd_wait_q <= 1'b0;
            ret_cnt_q <= 1'b1;
            st_q      <= ST_RELOAD;
          end else if (ch_last) st_q <= ST_DONE;
          else                  ch_q <= ch_q + 1'b1;
        end
        ST_RELOAD: begin
          if (!rd_wait_q) begin
            rd_wait_q <= 1'b1;
          end else begin
            logic fin;
            fin = 1'b0;
            rd_wait_q   <= 1'b0;
            ptr_q[ch_q] <= ptr_q[ch_q] + 1'b1;
            unique case (step_q)
              2'd0: begin
                cnt_q[ch_q] <= a_rdata_i;
                if (a_rdata_i == 8'd0) act_q[ch_q] <= 1'b0;
                if (cur_ind) begin
                  two_q  <= (a_rdata_i != 8'd0) || later_live;
                  step_q <= 2'd1;
                end else fin = 1'b1;
              end
              2'd1: begin
                if (two_q) begin
                  iad_q[ch_q][7:0] <= a_rdata_i;
                  step_q <= 2'd2;
                end else begin
                  iad_q[ch_q] <= {a_rdata_i, 8'h00};
                  fin = 1'b1;
                end
              end
              default: begin
                iad_q[ch_q][15:8] <= a_rdata_i;
                fin = 1'b1;
              end
            endcase
            if (fin) begin
              pend_q[ch_q] <= 1'b1;
              if (ch_last) st_q <= ST_DONE;
              else begin
                ch_q <= ch_q + 1'b1;
                st_q <= ret_cnt_q ? ST_COUNT : ST_INIT;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  rd_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_o |=> !a_rd_o);

  // R7
  b_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_wr_o |-> $past(a_rd_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  scan_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && $past(st_q) == ST_XFER) |-> ch_q >= $past(ch_q));
endmodule

// File: tb/hdma_engine_test.sv
module hdma_engine_test;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_start = 1'b0, hblank = 1'b0;
  logic [NCH-1:0]   en_mask = '0;
  logic [8*NCH-1:0] ctrl_v = '0, dest_v = '0, tbank_v = '0, ibank_v = '0;
  logic [16*NCH-1:0] tbl_v = '0;
  logic a_rd, b_wr, done;
  logic [23:0] a_addr;
  logic [7:0]  a_rdata = 8'h00, b_wdata;
  logic [15:0] b_addr;

  always #5 clk = ~clk;

  hdma_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start), .hblank_i(hblank),
    .en_mask_i(en_mask), .ctrl_i(ctrl_v), .dest_i(dest_v), .tbl_addr_i(tbl_v),
    .tbl_bank_i(tbank_v), .ind_bank_i(ibank_v),
    .a_rd_o(a_rd), .a_addr_o(a_addr), .a_rdata_i(a_rdata),
    .b_wr_o(b_wr), .b_addr_o(b_addr), .b_wdata_o(b_wdata), .done_o(done)
  );

  logic [7:0] mem [0:4095];
  always @(posedge clk) if (a_rd) a_rdata <= mem[{a_addr[16], a_addr[10:0]}];

  int checks = 0, fails = 0;
  string cur_req = "R1";

  logic [7:0]  cfg_ctrl [NCH], cfg_dest [NCH], cfg_tbank [NCH], cfg_ibank [NCH];
  logic [15:0] cfg_tbl [NCH];
  logic [NCH-1:0] cfg_en;

  // behavioural model state
  logic [NCH-1:0] m_act, m_pend;
  logic [7:0]  m_cnt [NCH];
  logic [15:0] m_ptr [NCH], m_iad [NCH];
  logic [23:0] q_rd [$];
  logic [23:0] q_wr [$];

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_read(input logic [7:0] bank, input logic [15:0] a, output logic [7:0] d);
    q_rd.push_back({bank, a});
    d = mem[{bank[0], a[10:0]}];
  endtask

  function automatic int plen(input logic [2:0] m);
    if (m == 3'd0) return 1;
    if (m == 3'd1 || m == 3'd2 || m == 3'd6) return 2;
    return 4;
  endfunction

  function automatic int poff(input logic [2:0] m, input int k);
    case (m)
      3'd0, 3'd2, 3'd6: return 0;
      3'd1, 3'd4:       return k;
      3'd3, 3'd7:       return k / 2;
      default:          return k % 2;
    endcase
  endfunction

  function automatic logic later_live(input int c);
    for (int j = c + 1; j < NCH; j++) if (m_act[j] && m_cnt[j] != 8'd0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_load(input int c);
    logic [7:0] n, b0, b1;
    logic two;
    m_read(cfg_tbank[c], m_ptr[c], n); m_ptr[c]++;
    m_cnt[c] = n;
    if (cfg_ctrl[c][6]) begin
      two = (n != 8'd0) || later_live(c);
      m_read(cfg_tbank[c], m_ptr[c], b0); m_ptr[c]++;
      if (two) begin
        m_read(cfg_tbank[c], m_ptr[c], b1); m_ptr[c]++;
        m_iad[c] = {b1, b0};
      end else m_iad[c] = {b0, 8'h00};
    end
    if (n == 8'd0) m_act[c] = 1'b0;
    m_pend[c] = 1'b1;
  endtask

  task automatic m_frame();
    m_act = cfg_en; m_pend = '0;
    for (int c = 0; c < NCH; c++) m_cnt[c] = 8'd0;
    for (int c = 0; c < NCH; c++)
      if (m_act[c]) begin m_ptr[c] = cfg_tbl[c]; m_load(c); end
  endtask

  task automatic m_hblank();
    logic [7:0] d;
    for (int c = 0; c < NCH; c++)
      if (m_act[c] && m_pend[c])
        for (int k = 0; k < plen(cfg_ctrl[c][2:0]); k++) begin
          if (cfg_ctrl[c][6]) begin m_read(cfg_ibank[c], m_iad[c], d); m_iad[c]++; end
          else begin m_read(cfg_tbank[c], m_ptr[c], d); m_ptr[c]++; end
          q_wr.push_back({16'h2100 + 16'(cfg_dest[c]) + 16'(poff(cfg_ctrl[c][2:0], k)), d});
        end
    for (int c = 0; c < NCH; c++)
      if (m_act[c]) begin
        m_cnt[c]--;
        m_pend[c] = m_cnt[c][7];
        if (m_cnt[c][6:0] == 7'd0) m_load(c);
      end
  endtask

  // stream comparison every clock
  always @(negedge clk) if (rst_ni) begin
    if (a_rd) begin
      if (q_rd.size() == 0) chk({cur_req, " unexpected read"}, 1'b0, {8'h0, a_addr}, 32'h0);
      else begin
        logic [23:0] e;
        e = q_rd.pop_front();
        chk({cur_req, " read addr"}, a_addr == e, {8'h0, a_addr}, {8'h0, e});
      end
    end
    if (b_wr) begin
      if (q_wr.size() == 0) chk({cur_req, " unexpected write"}, 1'b0, {8'h0, b_addr, b_wdata}, 32'h0);
      else begin
        logic [23:0] e;
        e = q_wr.pop_front();
        chk({cur_req, " write"}, {b_addr, b_wdata} == e, {8'h0, b_addr, b_wdata}, {8'h0, e});
      end
    end
  end

  task automatic apply_cfg();
    en_mask = cfg_en;
    for (int c = 0; c < NCH; c++) begin
      ctrl_v[c*8 +: 8]   = cfg_ctrl[c];
      dest_v[c*8 +: 8]   = cfg_dest[c];
      tbank_v[c*8 +: 8]  = cfg_tbank[c];
      ibank_v[c*8 +: 8]  = cfg_ibank[c];
      tbl_v[c*16 +: 16]  = cfg_tbl[c];
    end
  endtask

  task automatic clear_cfg();
    cfg_en = '0;
    for (int c = 0; c < NCH; c++) begin
      cfg_ctrl[c] = 8'h00; cfg_dest[c] = 8'h00; cfg_tbank[c] = 8'h00;
      cfg_ibank[c] = 8'h00; cfg_tbl[c] = 16'h0000;
    end
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13 + 5);
  endtask

  task automatic wait_done();
    logic seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk("R11 done seen", seen, {31'h0, seen}, 32'h1);
    @(negedge clk);
    chk("R11 done single cycle", !done, {31'h0, done}, 32'h0);
    chk({cur_req, " reads drained"}, q_rd.size() == 0, q_rd.size(), 32'h0);
    chk({cur_req, " writes drained"}, q_wr.size() == 0, q_wr.size(), 32'h0);
  endtask

  task automatic do_frame();
    m_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    wait_done();
  endtask

  task automatic do_line(input logic poke_busy);
    m_hblank();
    @(negedge clk) hblank = 1'b1;
    @(negedge clk) hblank = 1'b0;
    if (poke_busy) begin
      // R11: pulses during a running pass must be ignored
      frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0; hblank = 1'b1;
      @(negedge clk) hblank = 1'b0;
    end
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_cfg();
    apply_cfg();
    repeat (3) @(negedge clk);
    // R12: idle outputs in reset
    chk("R12 reset rd", !a_rd, {31'h0, a_rd}, 32'h0);
    chk("R12 reset wr", !b_wr, {31'h0, b_wr}, 32'h0);
    chk("R12 reset done", !done, {31'h0, done}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 idle after reset", !a_rd && !b_wr && !done, {29'h0, a_rd, b_wr, done}, 32'h0);

    // Scenario A: R1 R2 R5 R7 R8 R9 R10 mixed channels, ch3 disabled
    cur_req = "R1/R5/R9";
    clear_cfg();
    cfg_en = 8'b1010_0101;
    cfg_ctrl[0] = 8'h00; cfg_dest[0] = 8'h10; cfg_tbl[0] = 16'h0100;
    mem[12'h100] = 8'h02; mem[12'h102] = 8'h81; mem[12'h104] = 8'h00;
    cfg_ctrl[2] = 8'h01; cfg_dest[2] = 8'h18; cfg_tbl[2] = 16'h0200;
    mem[12'h200] = 8'h83; mem[12'h207] = 8'h01; mem[12'h20A] = 8'h00;
    cfg_ctrl[3] = 8'h04; cfg_dest[3] = 8'h50; cfg_tbl[3] = 16'h0280;
    mem[12'h280] = 8'h85;
    cfg_ctrl[5] = 8'h44; cfg_dest[5] = 8'h22; cfg_tbl[5] = 16'h0300; cfg_ibank[5] = 8'h01;
    mem[12'h300] = 8'h82; mem[12'h301] = 8'h40; mem[12'h302] = 8'h04; mem[12'h303] = 8'h00;
    cfg_ctrl[7] = 8'h07; cfg_dest[7] = 8'h30; cfg_tbl[7] = 16'h0400;
    mem[12'h400] = 8'h03; mem[12'h405] = 8'h00;
    apply_cfg();
    do_frame();
    cur_req = "R7/R8/R9/R10";
    for (int l = 0; l < 6; l++) do_line(1'b0);

    // Scenario B: R4 truncated pointer fetch, R3 full fetch
    cur_req = "R3/R4";
    clear_cfg();
    cfg_en = 8'b0000_0101;
    cfg_ctrl[0] = 8'h40; cfg_dest[0] = 8'h04; cfg_tbl[0] = 16'h0500; cfg_ibank[0] = 8'h01;
    mem[12'h500] = 8'h01; mem[12'h501] = 8'h10; mem[12'h502] = 8'h05; mem[12'h503] = 8'h00;
    cfg_ctrl[2] = 8'h42; cfg_dest[2] = 8'h08; cfg_tbl[2] = 16'h0600; cfg_ibank[2] = 8'h01;
    mem[12'h600] = 8'h00; mem[12'h601] = 8'h07;
    apply_cfg();
    do_frame();
    for (int l = 0; l < 3; l++) do_line(1'b0);

    // Scenario C: every pattern, R6, zero count with later live channels (R3), busy pulses (R11)
    cur_req = "R6/R3/R11";
    clear_cfg();
    cfg_en = 8'hFF;
    for (int c = 0; c < NCH; c++) begin
      cfg_ctrl[c] = 8'(c); cfg_dest[c] = 8'(8'h40 + 8 * c);
      cfg_tbl[c] = 16'(16'h0010 + 16'h0040 * c);
      mem[12'(16'h0010 + 16'h0040 * c)] = 8'h82;
      mem[12'(16'h0011 + 16'h0040 * c + 2 * plen(3'(c)))] = 8'h00;
    end
    cfg_ctrl[1] = 8'h41; cfg_ibank[1] = 8'h01;
    mem[12'h051] = 8'h20; mem[12'h052] = 8'h03; mem[12'h053] = 8'h00;
    apply_cfg();
    do_frame();
    do_line(1'b1);
    for (int l = 0; l < 3; l++) do_line(1'b0);

    // Scenario D: new frame after deactivation restores channels (R1/R5)
    cur_req = "R1/R5";
    do_frame();
    do_line(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule